// File: doc/BRIEF.md
# Battery-backed key store controller

The block sits on a simple 32-bit register bus and guards a small key store. The store has eight key words and one extra word. The key words can be written only after software enters programming mode by writing a magic value. That same write wipes the store first. Key words never read back. Software can confirm what it loaded by writing an expected checksum, and the block compares that value with a CRC it computes over the stored words.

The block also offers a self-clearing wipe command. The extra word has a set-only lock. A single interrupt source, an access-error pulse, has status, mask, unmask and mask-set registers. The key and extra words have no reset, so their contents survive a reset of the controller. The parameter `WO_WORD8` makes the extra word write-only. In that configuration the extra word reads as zero, is cleared by a wipe, counts toward the wiped flag, and cannot be locked.

Top module: `keystore_ctrl`

## Requirements
- R1: After reset the status register (0x00) reads 0, the lock register (0x4C) reads 0, the error-enable register (0x34) reads 0, the mask register (0x3C) reads 1, and both irq_o and busy_o are low.
- R2: Writing exactly 0x757BDF0D to the program-mode register (0x08) clears key words 0–7 and sets status bit 0 (programming) and status bit 4 (wiped). Bit 0 then stays set until reset. Any other value written there changes nothing.
- R3: A write to key words 0–7 (0x10–0x2C) is dropped unless status bit 0 is set. Reads of 0x10–0x2C and of the checksum register 0x0C always return 0.
- R4: Writing 1 to bit 0 of control (0x04) clears key words 0–7 and sets status bit 4. It also clears the extra word when WO_WORD8=1. Control always reads 0.
- R5: An accepted nonzero write to a key word clears status bit 4, and a zero write leaves it unchanged. A nonzero write to the extra word clears bit 4 only when WO_WORD8=1.
- R6: The extra word (0x30) accepts a write only while status bit 0 is 1 and the lock is 0. It reads back its value when WO_WORD8=0 and reads 0 when WO_WORD8=1. It keeps its value across reset.
- R7: Lock bit 0 (0x4C) can be set by a write but not cleared, and it stays set until reset. It stays 0 when WO_WORD8=1.
- R8: A write to 0x0C while status bit 0 is 1 raises busy_o for 9 cycles. After that, status bit 8 is 1 and status bit 9 shows whether the written value equals a reflected CRC-32 (polynomial 0x82F63B78, initial value 0, no final inversion) taken over one zero word followed by key words 0 through 7. The same write outside programming mode has no effect. Writes arriving while busy_o is high are dropped.
- R9: ISR bit 0 (0x38) is set by err_pulse_i when error-enable bit 0 is 1, and writing 1 to it clears it. irq_o equals ISR and not IMR. Writing 1 to 0x40 clears the mask and writing 1 to 0x44 sets it. Both of those registers read 0.
- R10: Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| err_pulse_i | input | 1 | One-cycle access-error event |
| rdata_o | output | 32 | Read data, registered, valid the cycle after rd_en_i |
| busy_o | output | 1 | Checksum engine running; writes are dropped |
| irq_o | output | 1 | Interrupt request |

## Verification
Key words cannot be read, so a wrong key value, a missed wipe or a write that should have been dropped appears only through the checksum verdict in status bit 9. That verdict arrives ten cycles after the checksum write. Flag errors are visible on the next status read: a stuck programming or lock bit, or a wiped flag that was cleared or not. A wrong mask or pending bit appears on irq_o in the cycle after the register write or error pulse. The extra word, read back when WO_WORD8=0, is what shows whether state was retained across reset.

// File: rtl/ks_pkg.sv
`timescale 1ns/1ps
package ks_pkg;
  localparam int unsigned OFF_STATUS = 'h00;
  localparam int unsigned OFF_CTRL   = 'h04;
  localparam int unsigned OFF_PGM    = 'h08;
  localparam int unsigned OFF_CRC    = 'h0C;
  localparam int unsigned OFF_KEY0   = 'h10;
  localparam int unsigned OFF_ERREN  = 'h34;
  localparam int unsigned OFF_ISR    = 'h38;
  localparam int unsigned OFF_IMR    = 'h3C;
  localparam int unsigned OFF_IER    = 'h40;
  localparam int unsigned OFF_IDR    = 'h44;
  localparam int unsigned OFF_LOCK   = 'h4C;

  localparam logic [31:0] PGM_MAGIC = 32'h757B_DF0D;
  localparam logic [31:0] CRC_POLY  = 32'h82F6_3B78;

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [31:0] d);
    logic [31:0] r;
    r = c ^ d;
    for (int i = 0; i < 32; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/ks_key_store.sv
`timescale 1ns/1ps
module ks_key_store #(
  parameter int unsigned KEY_WORDS = 8,
  parameter bit          WO_WORD8  = 1'b0,
  localparam int unsigned IDX_W    = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
  input  logic                       clk_i,
  input  logic                       clear_i,
  input  logic                       key_we_i,
  input  logic [IDX_W-1:0]           key_idx_i,
  input  logic                       w8_we_i,
  input  logic [31:0]                wdata_i,
  output logic [KEY_WORDS-1:0][31:0] keys_o,
  output logic [31:0]                word8_o
);
  // no reset: contents are retained across controller reset
  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
    always_ff @(posedge clk_i) begin
      if (clear_i) keys_o[i] <= '0;
      else if (key_we_i && key_idx_i == IDX_W'(i)) keys_o[i] <= wdata_i;
    end
  end

  if (WO_WORD8) begin : g_w8_wo
    always_ff @(posedge clk_i) begin
      if (clear_i) word8_o <= '0;
      else if (w8_we_i) word8_o <= wdata_i;
    end
  end else begin : g_w8_rw
    always_ff @(posedge clk_i) begin
      if (w8_we_i) word8_o <= wdata_i;
    end
  end
endmodule

// File: rtl/ks_crc_engine.sv
`timescale 1ns/1ps
module ks_crc_engine #(
  parameter int unsigned KEY_WORDS = 8,
  localparam int unsigned CNT_W    = $clog2(KEY_WORDS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [31:0]                ref_i,
  input  logic [KEY_WORDS-1:0][31:0] keys_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       match_o
);
  import ks_pkg::*;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      acc_q, ref_q, word_sel, acc_nxt;
  logic             last;

  // slot 0 feeds the leading zero word, slot i feeds key i-1
  always_comb begin
    word_sel = '0;
    for (int i = 0; i < KEY_WORDS; i++)
      if (cnt_q == CNT_W'(i + 1)) word_sel = keys_i[i];
  end

  assign acc_nxt = crc_step(acc_q, word_sel);
  assign last    = busy_q && (cnt_q == CNT_W'(KEY_WORDS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      ref_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      acc_q  <= '0;
      ref_q  <= ref_i;
    end else if (busy_q) begin
      acc_q <= acc_nxt;
      cnt_q <= cnt_q + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = last;
  assign match_o = (acc_nxt == ref_q);
endmodule

// File: rtl/ks_irq.sv
`timescale 1ns/1ps
module ks_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_pulse_i,
  input  logic err_en_i,
  input  logic isr_clr_i,
  input  logic unmask_i,
  input  logic mask_i,
  output logic isr_o,
  output logic imr_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_o <= 1'b0;
      imr_o <= 1'b1;
    end else begin
      if (err_pulse_i && err_en_i) isr_o <= 1'b1;
      else if (isr_clr_i)          isr_o <= 1'b0;
      if (mask_i)        imr_o <= 1'b1;
      else if (unmask_i) imr_o <= 1'b0;
    end
  end

  assign irq_o = isr_o & ~imr_o;
endmodule

// File: rtl/keystore_ctrl.sv
`timescale 1ns/1ps
module keystore_ctrl #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned KEY_WORDS = 8,
  parameter bit          WO_WORD8  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              err_pulse_i,
  output logic [31:0]       rdata_o,
  output logic              busy_o,
  output logic              irq_o
);
  import ks_pkg::*;

  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned IDX_W  = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
  localparam logic [WIDX_W-1:0] W_STATUS = WIDX_W'(OFF_STATUS >> 2);
  localparam logic [WIDX_W-1:0] W_CTRL   = WIDX_W'(OFF_CTRL >> 2);
  localparam logic [WIDX_W-1:0] W_PGM    = WIDX_W'(OFF_PGM >> 2);
  localparam logic [WIDX_W-1:0] W_CRC    = WIDX_W'(OFF_CRC >> 2);
  localparam logic [WIDX_W-1:0] W_KEY0   = WIDX_W'(OFF_KEY0 >> 2);
  localparam logic [WIDX_W-1:0] W_WORD8  = WIDX_W'((OFF_KEY0 >> 2) + KEY_WORDS);
  localparam logic [WIDX_W-1:0] W_ERREN  = WIDX_W'(OFF_ERREN >> 2);
  localparam logic [WIDX_W-1:0] W_ISR    = WIDX_W'(OFF_ISR >> 2);
  localparam logic [WIDX_W-1:0] W_IMR    = WIDX_W'(OFF_IMR >> 2);
  localparam logic [WIDX_W-1:0] W_IER    = WIDX_W'(OFF_IER >> 2);
  localparam logic [WIDX_W-1:0] W_IDR    = WIDX_W'(OFF_IDR >> 2);
  localparam logic [WIDX_W-1:0] W_LOCK   = WIDX_W'(OFF_LOCK >> 2);

  logic [WIDX_W-1:0] widx, key_off;
  logic              wr_ok, hit_key, magic;
  logic              zap, key_we, w8_we, crc_start;
  logic              pgm_q, zero_q, crc_done_q, crc_pass_q, lock_q, erren_q;
  logic              eng_done, eng_match, isr, imr;
  logic [KEY_WORDS-1:0][31:0] keys;
  logic [31:0]       word8, rdata_q;
  logic              unused_addr;

  assign unused_addr = ^addr_i[1:0];
  assign widx    = addr_i[ADDR_W-1:2];
  assign key_off = widx - W_KEY0;
  assign hit_key = (widx >= W_KEY0) && (key_off < WIDX_W'(KEY_WORDS));
  assign magic   = (wdata_i == PGM_MAGIC);
  assign wr_ok   = wr_en_i && !busy_o;

  assign zap       = wr_ok && (((widx == W_CTRL) && wdata_i[0]) || ((widx == W_PGM) && magic));
  assign key_we    = wr_ok && hit_key && pgm_q;
  assign w8_we     = wr_ok && (widx == W_WORD8) && pgm_q && !lock_q;
  assign crc_start = wr_ok && (widx == W_CRC) && pgm_q;

  ks_key_store #(.KEY_WORDS(KEY_WORDS), .WO_WORD8(WO_WORD8)) u_store (
    .clk_i    (clk_i),
    .clear_i  (zap),
    .key_we_i (key_we),
    .key_idx_i(key_off[IDX_W-1:0]),
    .w8_we_i  (w8_we),
    .wdata_i  (wdata_i),
    .keys_o   (keys),
    .word8_o  (word8)
  );

  ks_crc_engine #(.KEY_WORDS(KEY_WORDS)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(crc_start),
    .ref_i  (wdata_i),
    .keys_i (keys),
    .busy_o (busy_o),
    .done_o (eng_done),
    .match_o(eng_match)
  );

  ks_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .err_pulse_i(err_pulse_i),
    .err_en_i   (erren_q),
    .isr_clr_i  (wr_ok && (widx == W_ISR) && wdata_i[0]),
    .unmask_i   (wr_ok && (widx == W_IER) && wdata_i[0]),
    .mask_i     (wr_ok && (widx == W_IDR) && wdata_i[0]),
    .isr_o      (isr),
    .imr_o      (imr),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pgm_q      <= 1'b0;
      zero_q     <= 1'b0;
      crc_done_q <= 1'b0;
      crc_pass_q <= 1'b0;
      lock_q     <= 1'b0;
      erren_q    <= 1'b0;
    end else begin
      if (wr_ok && (widx == W_PGM) && magic) pgm_q <= 1'b1;
      if (zap) zero_q <= 1'b1;
      else if ((key_we || (w8_we && WO_WORD8)) && (|wdata_i)) zero_q <= 1'b0;
      if (crc_start) begin
        crc_done_q <= 1'b0;
        crc_pass_q <= 1'b0;
      end else if (eng_done) begin
        crc_done_q <= 1'b1;
        crc_pass_q <= eng_match;
      end
      if (!WO_WORD8 && wr_ok && (widx == W_LOCK) && wdata_i[0]) lock_q <= 1'b1;
      if (wr_ok && (widx == W_ERREN)) erren_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_en_i) begin
      rdata_q <= '0;
      if (widx == W_STATUS)
        rdata_q <= {22'b0, crc_pass_q, crc_done_q, 3'b0, zero_q, 3'b0, pgm_q};
      else if (widx == W_WORD8 && !WO_WORD8) rdata_q <= word8;
      else if (widx == W_ERREN) rdata_q <= {31'b0, erren_q};
      else if (widx == W_ISR)   rdata_q <= {31'b0, isr};
      else if (widx == W_IMR)   rdata_q <= {31'b0, imr};
      else if (widx == W_LOCK)  rdata_q <= {31'b0, lock_q};
    end else rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ks_checker.sv
`timescale 1ns/1ps
module ks_checker #(
  parameter int unsigned ADDR_W   = 8,
  parameter bit          WO_WORD8 = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              busy_o,
  input logic              pgm_q,
  input logic              lock_q,
  input logic              zero_q,
  input logic              crc_done_q
);
  import ks_pkg::*;
  logic hit_ctrl, hit_crc;
  assign hit_ctrl = (addr_i == ADDR_W'(OFF_CTRL));
  assign hit_crc  = (addr_i == ADDR_W'(OFF_CRC));

  a_r2_pgm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni) !$fell(pgm_q));
  a_r7_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni) !$fell(lock_q));
  a_r7_lock_off_when_wo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(WO_WORD8 && lock_q));
  a_r4_zeroize_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !busy_o && hit_ctrl && wdata_i[0]) |=> zero_q);
  a_r8_done_follows_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_done_q) |-> $past(busy_o));
  a_r8_busy_from_crc_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_en_i && hit_crc && pgm_q));
endmodule

bind keystore_ctrl ks_checker #(.ADDR_W(ADDR_W), .WO_WORD8(WO_WORD8)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .busy_o    (busy_o),
  .pgm_q     (pgm_q),
  .lock_q    (lock_q),
  .zero_q    (zero_q),
  .crc_done_q(crc_done_q)
);

// File: tb/keystore_ctrl_test.sv
`timescale 1ns/1ps
module keystore_ctrl_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, err_pulse = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_m, rdata_w;
  logic busy_m, busy_w, irq_m, irq_w;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  keystore_ctrl #(.WO_WORD8(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .err_pulse_i(err_pulse), .rdata_o(rdata_m), .busy_o(busy_m), .irq_o(irq_m));
  keystore_ctrl #(.WO_WORD8(1'b1)) uut_wo (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .err_pulse_i(err_pulse), .rdata_o(rdata_w), .busy_o(busy_w), .irq_o(irq_w));

  localparam logic [31:0] MAGIC = 32'h757B_DF0D;

  function automatic logic [31:0] step(logic [31:0] c, logic [31:0] d);
    logic [31:0] r = c ^ d;
    for (int b = 0; b < 32; b++) r = r[0] ? ((r >> 1) ^ 32'h82F6_3B78) : (r >> 1);
    return r;
  endfunction

  function automatic logic [31:0] ref_crc(logic [7:0][31:0] k);
    logic [31:0] c = step(32'h0, 32'h0);
    for (int i = 0; i < 8; i++) c = step(c, k[i]);
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] m, output logic [31:0] w);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; m = rdata_m; w = rdata_w;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic pulse_err();
    @(negedge clk); err_pulse = 1'b1;
    @(negedge clk); err_pulse = 1'b0;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog got=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] m, w, exp, val;
    logic [7:0][31:0] k;
    void'($urandom(32'h0BAD_5EED));
    do_reset();

    // R1 reset state
    rd(8'h00, m, w); chk("R1 status", m, 0); chk("R1 status wo", w, 0);
    rd(8'h3C, m, w); chk("R1 imr", m, 1);
    rd(8'h4C, m, w); chk("R1 lock", m, 0);
    rd(8'h34, m, w); chk("R1 erren", m, 0);
    chk("R1 irq/busy", {irq_m, busy_m, irq_w, busy_w}, 0);

    // R10 status not writable
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, m, w); chk("R10 status ro", m, 0);

    // R2 wrong magic ignored
    wr(8'h08, MAGIC ^ 32'h1);
    rd(8'h00, m, w); chk("R2 bad magic", m, 0);

    // R4 zeroize outside program mode, R3/R5 dropped key write keeps flag
    wr(8'h04, 32'h1);
    rd(8'h00, m, w); chk("R4 zeroized flag", m, 32'h10); chk("R4 zeroized wo", w, 32'h10);
    rd(8'h04, m, w); chk("R4 ctrl reads 0", m, 0);
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h00, m, w); chk("R3 key write dropped", m, 32'h10);

    // R8 checksum write outside programming mode ignored
    wr(8'h0C, 32'h0);
    chk("R8 no busy outside pgm", busy_m, 0);
    rd(8'h00, m, w); chk("R8 no done outside pgm", m, 32'h10);

    // R2 magic
    wr(8'h08, MAGIC);
    rd(8'h00, m, w); chk("R2 pgm+zeroized", m, 32'h11); chk("R2 pgm wo", w, 32'h11);

    // R6 extra word readback
    wr(8'h30, 32'hA5A5_0001);
    rd(8'h30, m, w); chk("R6 word8 readback", m, 32'hA5A5_0001); chk("R6 word8 wo reads 0", w, 0);
    rd(8'h00, m, w); chk("R5 word8 nonzero no clear", m, 32'h11); chk("R5 word8 wo clears", w, 32'h01);

    // R3 reads of key and checksum registers
    wr(8'h14, 32'h1234_5678);
    rd(8'h14, m, w); chk("R3 key reads 0", m, 0);
    rd(8'h0C, m, w); chk("R3 crc reads 0", m, 0);
    rd(8'h00, m, w); chk("R5 nonzero key clears", m, 32'h01);

    // R4 zeroize then R8 checksum of zeros is 0
    wr(8'h04, 32'h1);
    wr(8'h18, 32'h0);
    rd(8'h00, m, w); chk("R5 zero write keeps flag", m, 32'h11);
    wr(8'h0C, ref_crc('0));
    chk("R8 busy starts", busy_m, 1);
    repeat (8) @(negedge clk);
    chk("R8 busy at 9th cycle", busy_m, 1);
    @(negedge clk);
    chk("R8 busy ends", busy_m, 0);
    rd(8'h00, m, w); chk("R4 keys cleared crc pass", m, 32'h311);

    // R8 random key patterns, match or mismatch
    for (int it = 0; it < 12; it++) begin
      for (int i = 0; i < 8; i++) begin
        k[i] = $urandom;
        wr(8'(8'h10 + 4 * i), k[i]);
      end
      exp = ref_crc(k);
      val = (it % 3 == 1) ? (exp ^ ($urandom | 32'h1)) : exp;
      wr(8'h0C, val);
      if (it == 11) wr(8'h04, 32'h1);  // dropped while busy
      repeat (10) @(negedge clk);
      rd(8'h00, m, w);
      chk("R8 crc verdict", m, {22'b0, (val == exp), 1'b1, 3'b0, (k == '0), 3'b0, 1'b1});
    end

    // R6 retention across reset
    do_reset();
    rd(8'h30, m, w); chk("R6 word8 kept over reset", m, 32'hA5A5_0001);
    rd(8'h00, m, w); chk("R2 pgm cleared by reset", m, 0);
    wr(8'h30, 32'h0BAD_0BAD);
    rd(8'h30, m, w); chk("R6 word8 locked outside pgm", m, 32'hA5A5_0001);
    wr(8'h08, MAGIC);
    rd(8'h30, m, w); chk("R2 word8 kept by magic", m, 32'hA5A5_0001);

    // R7 lock
    wr(8'h30, 32'h0000_D00D);
    wr(8'h4C, 32'h1);
    rd(8'h4C, m, w); chk("R7 lock set", m, 1); chk("R7 lock wo stays 0", w, 0);
    wr(8'h30, 32'h0000_E00E);
    rd(8'h30, m, w); chk("R6 word8 frozen by lock", m, 32'h0000_D00D);
    wr(8'h4C, 32'h0);
    rd(8'h4C, m, w); chk("R7 lock not clearable", m, 1);

    // R9 interrupt
    pulse_err();
    rd(8'h38, m, w); chk("R9 isr needs enable", m, 0);
    wr(8'h34, 32'h1);
    pulse_err();
    rd(8'h38, m, w); chk("R9 isr set", m, 1);
    chk("R9 masked irq", irq_m, 0);
    wr(8'h40, 32'h1);
    chk("R9 unmask raises irq", irq_m, 1);
    rd(8'h3C, m, w); chk("R9 imr cleared", m, 0);
    rd(8'h40, m, w); chk("R9 ier reads 0", m, 0);
    rd(8'h44, m, w); chk("R9 idr reads 0", m, 0);
    wr(8'h44, 32'h1);
    chk("R9 mask drops irq", irq_m, 0);
    wr(8'h40, 32'h1);
    wr(8'h38, 32'h1);
    chk("R9 w1c drops irq", irq_m, 0);
    rd(8'h38, m, w); chk("R9 isr cleared", m, 0);
    for (int it = 0; it < 6; it++) begin
      val = $urandom % 2;
      wr(8'h34, val);
      pulse_err();
      chk("R9 random pulse irq", irq_m, val);
      wr(8'h38, 32'h1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule